// File: doc/BRIEF.md
# Processor status control register

This block holds the 32-bit privileged status word of a small processor control unit. Software reads the assembled word at any time and replaces it through a write port gated by a write enable. Hardware events also change the word. These events are a hard reset, a soft reset, a non-maskable interrupt entry and a TLB write that would shut the TLB down. The block records which kind of reset-vector entry took place.

From the stored fields the block derives four outputs:
- the effective privilege mode, which is user only when no exception level, error level or debug state overrides it;
- the effective data endianness, which can be reversed only while in user mode;
- the bootstrap exception-vector select;
- one interrupt request, formed from the enable bit, the 8-bit mask field and an 8-bit pending input.

Three flags (TLB shutdown, soft-reset cause and NMI cause) are set only by hardware. Software can clear them but can never set them.

Top module: `proc_status_reg`

## Requirements
- R1: A hard reset (`rst_n` low at a clock edge, or `hard_rst_i` high at an edge) loads the following values. BEV (bit 22) = 1 and ERL (bit 2) = 1. TS (bit 21), SR (bit 20), NMI (bit 19), EXL (bit 1), IE (bit 0), RE (bit 25), IM (bits 15:8) and UM (bit 4) are all 0. The read word is therefore 0x00400004.
- R2: A soft-reset event (`soft_rst_i` high, no hard reset) sets SR=1, NMI=0, BEV=1, ERL=1, TS=0, EXL=0 and IE=0. RE, IM and UM keep their values. Priority among events is hard, then soft, then NMI. Any reset event overrides a software write in the same cycle.
- R3: An NMI event (`nmi_i` high, with no hard or soft reset) sets NMI=1, SR=0, BEV=1, ERL=1, TS=0, EXL=0 and IE=0. RE, IM and UM keep their values.
- R4: Every bit outside 25, 22..19, 15..8, 4 and 2..0 always reads 0, and writes to it have no effect. The mask of defined bits is 0x0278FF17.
- R5: When `sw_we_i` is high and no reset event occurs, RE, BEV, IM, UM, ERL, EXL and IE take the written bits at the clock edge. The new value appears on `sw_rdata_o` in the following cycle.
- R6: A software write changes each of TS, SR and NMI to (old AND written bit). Writing 1 never sets the flag.
- R7: `tlb_shutdown_i` high with no reset event sets TS. This holds even when a software write of 0 to TS occurs in the same cycle.
- R8: `irq_o` is 1 exactly when IE=1 and, for some i, IM[i] and `irq_pend_i[i]` are both 1.
- R9: `user_mode_o` is 1 exactly when UM=1, EXL=0, ERL=0 and `debug_i`=0. The stored UM bit is not changed by EXL, ERL or debug state.
- R10: `big_endian_o` equals `cfg_big_endian_i` XOR (RE AND `user_mode_o`).
- R11: `boot_vec_o` equals the stored BEV bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| hard_rst_i | input | 1 | Hard reset event pulse |
| soft_rst_i | input | 1 | Soft reset event pulse |
| nmi_i | input | 1 | NMI reset-vector entry pulse |
| tlb_shutdown_i | input | 1 | TLB write would cause shutdown |
| debug_i | input | 1 | Processor is in debug state |
| cfg_big_endian_i | input | 1 | Configured data endianness (1 = big) |
| irq_pend_i | input | 8 | Pending interrupt lines |
| sw_we_i | input | 1 | Software write enable |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Assembled status word |
| user_mode_o | output | 1 | Effective user mode |
| big_endian_o | output | 1 | Effective data endianness |
| boot_vec_o | output | 1 | Bootstrap exception vector select |
| irq_o | output | 1 | Interrupt request |

## Verification
The interrupt request is tried with three kinds of stimulus:
- a single mask bit walked against a single pending bit, which separates a per-line AND from a looser match;
- the same patterns with the enable bit cleared, which shows that the enable gates the request;
- random mask and pending words, which exercise multi-line overlap.

Privilege and endianness are swept over all combinations of UM, EXL, ERL, debug, RE and configured endianness, so that each override is seen alone. The reset-cause flags are driven with simultaneous events and with writes of 1 and of 0, which separates event priority, clear-only behaviour and set-beats-clear. A long random run mixes all inputs against the reference model.

// File: rtl/proc_status_pkg.sv
// Package: proc_status_pkg
// Shared bit positions, field widths and types of the status word.
// Assumes a 32-bit word and an 8-line interrupt mask.
package proc_status_pkg;

    localparam int WORD_W  = 32;
    localparam int IRQ_W   = 8;

    localparam int POS_RE  = 25;
    localparam int POS_BEV = 22;
    localparam int POS_TS  = 21;
    localparam int POS_SR  = 20;
    localparam int POS_NMI = 19;
    localparam int POS_IM  = 8;
    localparam int POS_UM  = 4;
    localparam int POS_ERL = 2;
    localparam int POS_EXL = 1;
    localparam int POS_IE  = 0;

    localparam int NUM_STICKY = 3;

    // Kind of reset-vector entry seen this cycle, already prioritised.
    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_HARD = 2'd1,
        RK_SOFT = 2'd2,
        RK_NMI  = 2'd3
    } rst_kind_e;

    // Plain software read/write fields.
    typedef struct packed {
        logic             re;
        logic             bev;
        logic [IRQ_W-1:0] im;
        logic             um;
        logic             erl;
        logic             exl;
        logic             ie;
    } rw_fields_t;

    // Bit position of sticky flag i (0: TS, 1: SR, 2: NMI).
    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return POS_TS;
            1:       return POS_SR;
            default: return POS_NMI;
        endcase
    endfunction

endpackage

// File: rtl/psr_reset_arb.sv
// Module: psr_reset_arb
// Turns the simultaneous reset-type event inputs into one prioritised kind:
// hard beats soft, soft beats NMI. Purely combinational.
module psr_reset_arb
    import proc_status_pkg::*;
(
    input  logic      hard_i,
    input  logic      soft_i,
    input  logic      nmi_i,
    output rst_kind_e kind_o
);

    // Priority encode the event inputs.
    always_comb begin
        if (hard_i)      kind_o = RK_HARD;
        else if (soft_i) kind_o = RK_SOFT;
        else if (nmi_i)  kind_o = RK_NMI;
        else             kind_o = RK_NONE;
    end

endmodule

// File: rtl/psr_sticky_flag.sv
// Module: psr_sticky_flag
// One hardware-set, software-clear-only flag. A load (reset event) forces
// load_val_i. Otherwise a write ANDs the flag with the written bit, and
// set_i then forces it to 1, so a hardware set wins over a clearing write.
// Assumes a synchronous active-low reset.
module psr_sticky_flag #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic load_val_i,
    input  logic we_i,
    input  logic wbit_i,
    input  logic set_i,
    output logic q_o
);

    logic q_next;

    // Next-state selection: load, then clear-only write, then hardware set.
    always_comb begin
        if (load_i) begin
            q_next = load_val_i;
        end else begin
            q_next = we_i ? (q_o & wbit_i) : q_o;
            if (set_i) q_next = 1'b1;
        end
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RESET_VAL;
        else        q_o <= q_next;
    end

    // A write can only clear; without a hardware set or load the flag never rises.
    assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !set_i && !q_o) |=> !q_o);

    // A hardware set outside a load leaves the flag at 1, even under a write.
    assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && set_i) |=> q_o);

endmodule

// File: rtl/psr_rw_fields.sv
// Module: psr_rw_fields
// Storage for the plain read/write fields. Any reset event forces BEV=1,
// ERL=1, EXL=0 and IE=0. Only a hard reset also clears RE, IM and UM.
// Otherwise a software write loads every field.
module psr_rw_fields
    import proc_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rst_kind_e  kind_i,
    input  logic       we_i,
    input  rw_fields_t wr_i,
    output rw_fields_t q_o
);

    rw_fields_t nxt;

    // Next-state selection: reset event, then software write, else hold.
    always_comb begin
        nxt = q_o;
        if (kind_i != RK_NONE) begin
            nxt.bev = 1'b1;
            nxt.erl = 1'b1;
            nxt.exl = 1'b0;
            nxt.ie  = 1'b0;
            if (kind_i == RK_HARD) begin
                nxt.re = 1'b0;
                nxt.im = '0;
                nxt.um = 1'b0;
            end
        end else if (we_i) begin
            nxt = wr_i;
        end
    end

    // Field storage with the hard-reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o     <= '0;
            q_o.bev <= 1'b1;
            q_o.erl <= 1'b1;
        end else begin
            q_o <= nxt;
        end
    end

    // Soft and NMI entries leave the mask untouched.
    assert_mask_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == RK_SOFT || kind_i == RK_NMI) |=> (q_o.im == $past(q_o.im)));

endmodule

// File: rtl/psr_irq_gen.sv
// Module: psr_irq_gen
// Interrupt request: enable AND the OR over all lines of (mask AND pending).
// The per-line terms are built with a generate loop.
module psr_irq_gen #(
    parameter int LINES = 8
) (
    input  logic             ie_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] pend_i,
    output logic             irq_o
);

    logic [LINES-1:0] hit;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign hit[g] = mask_i[g] & pend_i[g];
    end

    // Combine the per-line hits with the global enable.
    always_comb irq_o = ie_i & (|hit);

endmodule

// File: rtl/psr_mode_out.sv
// Module: psr_mode_out
// Derives effective privilege, effective endianness and the vector select
// from the stored fields. Assumes the debug state is held by the caller.
module psr_mode_out (
    input  logic um_i,
    input  logic exl_i,
    input  logic erl_i,
    input  logic re_i,
    input  logic bev_i,
    input  logic debug_i,
    input  logic cfg_big_i,
    output logic user_o,
    output logic big_o,
    output logic boot_o
);

    // User only when no exception, error or debug override is active.
    always_comb user_o = um_i & ~exl_i & ~erl_i & ~debug_i;

    // Reversal applies only to effective user-mode accesses.
    always_comb big_o = cfg_big_i ^ (re_i & user_o);

    // Vector base select follows the stored bit.
    always_comb boot_o = bev_i;

endmodule

// File: rtl/proc_status_reg.sv
// Module: proc_status_reg
// Top of the status register. It arbitrates the reset events, holds the
// read/write fields and the three sticky flags, assembles the read word and
// drives the mode, endianness, vector and interrupt outputs.
// Assumes a synchronous active-low reset and single-cycle event pulses.
module proc_status_reg
    import proc_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst_i,
    input  logic              soft_rst_i,
    input  logic              nmi_i,
    input  logic              tlb_shutdown_i,
    input  logic              debug_i,
    input  logic              cfg_big_endian_i,
    input  logic [IRQ_W-1:0]  irq_pend_i,
    input  logic              sw_we_i,
    input  logic [WORD_W-1:0] sw_wdata_i,
    output logic [WORD_W-1:0] sw_rdata_o,
    output logic              user_mode_o,
    output logic              big_endian_o,
    output logic              boot_vec_o,
    output logic              irq_o
);

    rst_kind_e             kind;
    rw_fields_t            rw_q;
    rw_fields_t            rw_wr;
    logic [NUM_STICKY-1:0] sticky_q;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_lval;
    logic                  any_evt;
    logic                  unused_wbits;

    psr_reset_arb u_arb (
        .hard_i (hard_rst_i),
        .soft_i (soft_rst_i),
        .nmi_i  (nmi_i),
        .kind_o (kind)
    );

    assign any_evt = (kind != RK_NONE);

    // Unpack the written word into the read/write field struct.
    always_comb begin
        rw_wr.re  = sw_wdata_i[POS_RE];
        rw_wr.bev = sw_wdata_i[POS_BEV];
        rw_wr.im  = sw_wdata_i[POS_IM +: IRQ_W];
        rw_wr.um  = sw_wdata_i[POS_UM];
        rw_wr.erl = sw_wdata_i[POS_ERL];
        rw_wr.exl = sw_wdata_i[POS_EXL];
        rw_wr.ie  = sw_wdata_i[POS_IE];
    end

    // Reserved write bits are deliberately dropped.
    assign unused_wbits = ^sw_wdata_i;

    psr_rw_fields u_rw (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (kind),
        .we_i   (sw_we_i),
        .wr_i   (rw_wr),
        .q_o    (rw_q)
    );

    // Per-flag hardware set sources and load values on a reset event.
    always_comb begin
        sticky_set     = '0;
        sticky_set[0]  = tlb_shutdown_i;
        sticky_lval    = '0;
        sticky_lval[1] = (kind == RK_SOFT);
        sticky_lval[2] = (kind == RK_NMI);
    end

    for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
        localparam int BITPOS = sticky_pos(g);
        psr_sticky_flag #(.RESET_VAL(1'b0)) u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (any_evt),
            .load_val_i (sticky_lval[g]),
            .we_i       (sw_we_i),
            .wbit_i     (sw_wdata_i[BITPOS]),
            .set_i      (sticky_set[g]),
            .q_o        (sticky_q[g])
        );
    end

    // Assemble the read word; undefined positions stay zero.
    always_comb begin
        sw_rdata_o                     = '0;
        sw_rdata_o[POS_RE]             = rw_q.re;
        sw_rdata_o[POS_BEV]            = rw_q.bev;
        sw_rdata_o[POS_TS]             = sticky_q[0];
        sw_rdata_o[POS_SR]             = sticky_q[1];
        sw_rdata_o[POS_NMI]            = sticky_q[2];
        sw_rdata_o[POS_IM +: IRQ_W]    = rw_q.im;
        sw_rdata_o[POS_UM]             = rw_q.um;
        sw_rdata_o[POS_ERL]            = rw_q.erl;
        sw_rdata_o[POS_EXL]            = rw_q.exl;
        sw_rdata_o[POS_IE]             = rw_q.ie;
    end

    psr_mode_out u_mode (
        .um_i      (rw_q.um),
        .exl_i     (rw_q.exl),
        .erl_i     (rw_q.erl),
        .re_i      (rw_q.re),
        .bev_i     (rw_q.bev),
        .debug_i   (debug_i),
        .cfg_big_i (cfg_big_endian_i),
        .user_o    (user_mode_o),
        .big_o     (big_endian_o),
        .boot_o    (boot_vec_o)
    );

    psr_irq_gen #(.LINES(IRQ_W)) u_irq (
        .ie_i   (rw_q.ie),
        .mask_i (rw_q.im),
        .pend_i (irq_pend_i),
        .irq_o  (irq_o)
    );

    // After a hard reset pulse the vector is bootstrap and error level is set.
    assert_hard_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst_i |=> (boot_vec_o && sw_rdata_o[POS_ERL] && !irq_o && !user_mode_o));

    // A soft reset records its cause and clears the NMI cause.
    assert_soft_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_i && !hard_rst_i) |=> (sw_rdata_o[POS_SR] && !sw_rdata_o[POS_NMI]));

    // An NMI alone records its cause and clears the soft cause.
    assert_nmi_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && !soft_rst_i && !hard_rst_i) |=> (sw_rdata_o[POS_NMI] && !sw_rdata_o[POS_SR]));

    // A write with no event lands in the vector-select bit one cycle later.
    assert_rw_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we_i && !hard_rst_i && !soft_rst_i && !nmi_i)
        |=> (boot_vec_o == $past(sw_wdata_i[POS_BEV])));

endmodule

// File: tb/proc_status_reg_tb.sv
// Bench: behavioural reference model stepped with the DUT and compared every cycle.
module proc_status_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hard_rst_i, soft_rst_i, nmi_i, tlb_shutdown_i;
    logic        debug_i, cfg_big_endian_i;
    logic [7:0]  irq_pend_i;
    logic        sw_we_i;
    logic [31:0] sw_wdata_i;
    logic [31:0] sw_rdata_o;
    logic        user_mode_o, big_endian_o, boot_vec_o, irq_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Reference state.
    bit       m_re, m_bev, m_ts, m_sr, m_nmi, m_um, m_erl, m_exl, m_ie;
    bit [7:0] m_im;

    always #10 clk = ~clk;

    proc_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .hard_rst_i(hard_rst_i), .soft_rst_i(soft_rst_i),
        .nmi_i(nmi_i), .tlb_shutdown_i(tlb_shutdown_i), .debug_i(debug_i),
        .cfg_big_endian_i(cfg_big_endian_i), .irq_pend_i(irq_pend_i),
        .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i), .sw_rdata_o(sw_rdata_o),
        .user_mode_o(user_mode_o), .big_endian_o(big_endian_o),
        .boot_vec_o(boot_vec_o), .irq_o(irq_o)
    );

    function automatic bit [31:0] exp_word();
        bit [31:0] w = 32'h0;
        w[25] = m_re; w[22] = m_bev; w[21] = m_ts; w[20] = m_sr; w[19] = m_nmi;
        w[15:8] = m_im; w[4] = m_um; w[2] = m_erl; w[1] = m_exl; w[0] = m_ie;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference update: hard, soft, NMI, then software write, then TLB set.
    task automatic model_edge();
        if (!rst_n || hard_rst_i) begin
            m_re = 0; m_im = 0; m_um = 0;
            m_bev = 1; m_erl = 1; m_exl = 0; m_ie = 0;
            m_ts = 0; m_sr = 0; m_nmi = 0;
        end else if (soft_rst_i || nmi_i) begin
            m_bev = 1; m_erl = 1; m_exl = 0; m_ie = 0; m_ts = 0;
            m_sr  = soft_rst_i;
            m_nmi = !soft_rst_i;
        end else begin
            if (sw_we_i) begin
                m_re = sw_wdata_i[25]; m_bev = sw_wdata_i[22]; m_im = sw_wdata_i[15:8];
                m_um = sw_wdata_i[4]; m_erl = sw_wdata_i[2]; m_exl = sw_wdata_i[1];
                m_ie = sw_wdata_i[0];
                if (!sw_wdata_i[21]) m_ts = 0;
                if (!sw_wdata_i[20]) m_sr = 0;
                if (!sw_wdata_i[19]) m_nmi = 0;
            end
            if (tlb_shutdown_i) m_ts = 1;
        end
    endtask

    // One cycle: clock edge, model update, compare on the falling edge.
    task automatic step(input string tag);
        bit exp_user, exp_big, exp_irq;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_user = m_um && !m_exl && !m_erl && !debug_i;
        exp_big  = cfg_big_endian_i ^ (m_re && exp_user);
        exp_irq  = m_ie && ((m_im & irq_pend_i) != 8'h0);
        chk(sw_rdata_o === exp_word(), tag, sw_rdata_o, exp_word());
        chk(irq_o === exp_irq, "R8 irq", {31'h0, irq_o}, {31'h0, exp_irq});
        chk(user_mode_o === exp_user, "R9 user", {31'h0, user_mode_o}, {31'h0, exp_user});
        chk(big_endian_o === exp_big, "R10 endian", {31'h0, big_endian_o}, {31'h0, exp_big});
        chk(boot_vec_o === m_bev, "R11 bootvec", {31'h0, boot_vec_o}, {31'h0, m_bev});
        hard_rst_i = 0; soft_rst_i = 0; nmi_i = 0; tlb_shutdown_i = 0; sw_we_i = 0;
    endtask

    task automatic wr(input logic [31:0] d, input string tag);
        sw_we_i = 1; sw_wdata_i = d;
        step(tag);
    endtask

    initial begin
        rst_n = 0; hard_rst_i = 0; soft_rst_i = 0; nmi_i = 0; tlb_shutdown_i = 0;
        debug_i = 0; cfg_big_endian_i = 0; irq_pend_i = 0; sw_we_i = 0; sw_wdata_i = 0;
        step("R1 reset"); step("R1 reset");
        chk(sw_rdata_o === 32'h0040_0004, "R1 reset word", sw_rdata_o, 32'h0040_0004);
        rst_n = 1;
        step("R1 idle");
        // R4: reserved bits, R6: writing ones cannot set sticky flags.
        wr(32'hFFFF_FFFF, "R4 all ones");
        chk((sw_rdata_o & ~32'h0278_FF17) === 32'h0, "R4 reserved", sw_rdata_o, 32'h0);
        chk(sw_rdata_o[21:19] === 3'b000, "R6 no sw set", {29'h0, sw_rdata_o[21:19]}, 32'h0);
        wr(32'h0000_A513, "R5 pattern a");
        wr(32'h0240_5A06, "R5 pattern b");
        // R7: TLB set, then set against clearing write.
        tlb_shutdown_i = 1; step("R7 tlb set");
        tlb_shutdown_i = 1; wr(32'h0000_0000, "R7 set beats clear");
        wr(32'h0020_0000, "R6 write one keeps TS");
        wr(32'h0000_0000, "R6 clear TS");
        // R2: soft reset keeps RE/IM/UM and beats a write.
        wr(32'h0200_C313, "R5 setup");
        soft_rst_i = 1; sw_we_i = 1; sw_wdata_i = 32'h0; step("R2 soft reset");
        wr(32'h0210_C310, "R6 SR write one");
        wr(32'h0200_C310, "R6 SR clear");
        // R3: NMI alone, then soft+NMI together.
        nmi_i = 1; tlb_shutdown_i = 1; step("R3 nmi entry");
        soft_rst_i = 1; nmi_i = 1; step("R2 soft over nmi");
        nmi_i = 1; step("R3 nmi after soft");
        hard_rst_i = 1; soft_rst_i = 1; step("R1 hard pulse");
        // R8: walk one mask line against one pending line.
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                wr({16'h0, 8'h1 << i, 8'h01}, "R5 mask");
                irq_pend_i = 8'h1 << j; step("R8 walk");
                wr({16'h0, 8'h1 << i, 8'h00}, "R8 ie off");
            end
        end
        // R9/R10: all mode and endianness combinations.
        for (int k = 0; k < 64; k++) begin
            debug_i = k[3]; cfg_big_endian_i = k[5];
            wr({6'h0, k[4], 9'h0, 8'h0, 3'h0, k[0], 1'b0, k[2], k[1], 1'b0}, "R9 R10 combo");
            step("R9 R10 hold");
        end
        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r = $urandom;
            hard_rst_i = (r[7:0] == 8'h3); soft_rst_i = (r[7:3] == 5'h2);
            nmi_i = (r[7:3] == 5'h5); tlb_shutdown_i = r[8] & r[9];
            debug_i = r[10] & r[11]; cfg_big_endian_i = r[12];
            irq_pend_i = r[20:13]; sw_we_i = r[21];
            sw_wdata_i = $urandom;
            step("R5 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog act=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule